// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This controller sits on the host side of a parallel flash. Once a separate command sequencer has sent a program or erase, it works out when the device has finished. It latches the operation type, the expected byte, the target address and a read budget on a start pulse. It then waits for the sequencer to report that its last command write is complete. After that it keeps reading the target address over a single-master read channel and watches the status bits to decide when the operation has ended.

There are two detection schemes, chosen per operation by an input. In complemented-data polling, the top data bit reads back inverted (program) or zero (erase) until the operation ends. In toggle polling, the next-to-top bit changes on every read while the device is busy. When either scheme sees completion, the poller waits a settling interval, because the rest of the byte may not be valid yet. It then does one full read and pulses `done`, with a mismatch flag for programs. If completion never appears within the read budget, it ends with a timeout instead.

Top module: `flash_done_poller`

## Requirements
- R1: In complemented-data mode (`use_toggle`=0) for a program (`op_erase`=0), a poll read completes the operation when `rd_data[7]` equals bit 7 of the latched expected byte.
- R2: In complemented-data mode for an erase (`op_erase`=1), a poll read completes the operation when `rd_data[7]` is 1, whatever the expected byte holds.
- R3: In toggle mode (`use_toggle`=1), a poll read completes the operation when its `rd_data[6]` equals `rd_data[6]` of the previous poll read of the same operation. The first poll read never completes.
- R4: After the completing poll read, `rd_req` stays low for exactly SETTLE_CYC cycles. Exactly one more read follows, and `done` is high for one cycle, in the cycle after that read's `rd_ack`.
- R5: After a start, no read is requested until a `cmd_wr_done` pulse has been seen. The first poll read is requested in the cycle after that pulse.
- R6: Between two poll reads `rd_req` is low for exactly GAP_CYC cycles. Once raised, `rd_req` stays high with a steady `rd_addr` until `rd_ack`. `rd_addr` always carries the address latched at start.
- R7: If max(`max_reads`,1) poll reads pass without completion, `done` and `timeout` pulse together in the cycle after the last read's acknowledge, and no settle or final read occurs.
- R8: `mismatch` pulses with `done` only for a program whose final read differs from the expected byte in any bit. It is never raised for an erase or together with `timeout`.
- R9: After reset `busy`, `done`, `timeout`, `mismatch` and `rd_req` are low. A `start` while busy changes nothing in the running operation, and a `cmd_wr_done` while idle starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch pulse, accepted only when idle |
| op_erase | input | 1 | 1 = erase, 0 = program |
| use_toggle | input | 1 | 1 = toggle-bit detection, 0 = complemented-data detection |
| exp_data | input | DW | Byte written by the program |
| addr | input | AW | Address to poll |
| max_reads | input | CW | Poll read budget (0 treated as 1) |
| cmd_wr_done | input | 1 | Pulse from the sequencer: last command write finished |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge, one cycle, with data |
| rd_data | input | DW | Read data, valid with `rd_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout | output | 1 | With `done`: budget exhausted |
| mismatch | output | 1 | With `done`: program final byte differs from expected |

## Verification
The hardest state to reach from the ports is the one where completion has already been seen but the byte is still settling. Here the poll read that completes the operation carries correct status bits and wrong low bits, so only the settle-then-final-read rule prevents a false mismatch. The bench device model returns exactly such a half-valid byte on the first read after its busy phase. It also toggles bit 6 against the final value in both phases, so toggle-mode completion lands either on that half-valid read or on the read after it. The read counts and the low-time runs of `rd_req` are compared against a reference walk of the same read sequence.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CMD,
    ST_READ,
    ST_GAP,
    ST_SETTLE,
    ST_FINAL
  } poll_state_t;

  // complemented-data rule: erase ends on a 1, program on true data
  function automatic logic dpoll_hit(input logic erase, input logic exp_top,
                                     input logic rd_top);
    return erase ? rd_top : (rd_top == exp_top);
  endfunction

  // toggle rule: two equal consecutive samples of the toggling bit
  function automatic logic toggle_hit(input logic have_prev, input logic prev_bit,
                                      input logic rd_bit);
    return have_prev && (prev_bit == rd_bit);
  endfunction

  // budget of zero behaves as one read
  function automatic logic budget_spent(input logic [15:0] reads_after,
                                        input logic [15:0] budget);
    logic [15:0] eff;
    eff = (budget == 16'd0) ? 16'd1 : budget;
    return reads_after >= eff;
  endfunction

endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));  // R4
  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);  // R6

endmodule

// File: rtl/poll_judge.sv
module poll_judge
  import poll_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          use_toggle,
  input  logic          erase,
  input  logic [DW-1:0] exp_byte,
  input  logic [DW-1:0] rd_byte,
  input  logic          have_prev,
  input  logic          prev_bit,
  output logic          hit
);

  localparam int TOP = DW - 1;
  localparam int TGL = DW - 2;

  logic data_hit;
  logic tog_hit;

  always_comb begin
    data_hit = dpoll_hit(erase, exp_byte[TOP], rd_byte[TOP]);
    tog_hit  = toggle_hit(have_prev, prev_bit, rd_byte[TGL]);
    hit      = use_toggle ? tog_hit : data_hit;
  end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import poll_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 8,
  parameter int CW         = 8,
  parameter int GAP_CYC    = 4,
  parameter int SETTLE_CYC = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic          use_toggle,
  input  logic [DW-1:0] exp_data,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] max_reads,
  input  logic          cmd_wr_done,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic          mismatch
);

  localparam int TMAX = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] GAP_LOAD    = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] SETTLE_LOAD = TW'(SETTLE_CYC - 1);
  localparam int TGL = DW - 2;

  poll_state_t   state, state_nxt;
  logic          erase_q;
  logic          toggle_q;
  logic [DW-1:0] exp_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] limit_q;
  logic [CW-1:0] poll_cnt;
  logic          have_prev;
  logic          prev_bit;
  logic          done_q, timeout_q, mismatch_q;

  // named events for the assertions
  logic          poll_ack;
  logic          final_ack;
  logic          poll_hit;
  logic          poll_last;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          accept_start;

  poll_judge #(.DW(DW)) i_judge (
    .use_toggle (toggle_q),
    .erase      (erase_q),
    .exp_byte   (exp_q),
    .rd_byte    (rd_data),
    .have_prev  (have_prev),
    .prev_bit   (prev_bit),
    .hit        (poll_hit)
  );

  poll_timer #(.TW(TW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    accept_start = (state == ST_IDLE) && start;
    poll_ack     = (state == ST_READ) && rd_ack;
    final_ack    = (state == ST_FINAL) && rd_ack;
    poll_last    = budget_spent(16'(poll_cnt) + 16'd1, 16'(limit_q));
    tmr_load     = poll_ack && (poll_hit || !poll_last);
    tmr_val      = poll_hit ? SETTLE_LOAD : GAP_LOAD;
  end

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:     if (start)       state_nxt = ST_WAIT_CMD;
      ST_WAIT_CMD: if (cmd_wr_done) state_nxt = ST_READ;
      ST_READ: begin
        if (rd_ack) begin
          if (poll_hit)       state_nxt = ST_SETTLE;
          else if (poll_last) state_nxt = ST_IDLE;
          else                state_nxt = ST_GAP;
        end
      end
      ST_GAP:      if (tmr_zero) state_nxt = ST_READ;
      ST_SETTLE:   if (tmr_zero) state_nxt = ST_FINAL;
      ST_FINAL:    if (rd_ack)   state_nxt = ST_IDLE;
      default:                   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      erase_q    <= 1'b0;
      toggle_q   <= 1'b0;
      exp_q      <= '0;
      addr_q     <= '0;
      limit_q    <= '0;
      poll_cnt   <= '0;
      have_prev  <= 1'b0;
      prev_bit   <= 1'b0;
      done_q     <= 1'b0;
      timeout_q  <= 1'b0;
      mismatch_q <= 1'b0;
    end else begin
      state      <= state_nxt;
      done_q     <= 1'b0;
      timeout_q  <= 1'b0;
      mismatch_q <= 1'b0;
      if (accept_start) begin
        erase_q   <= op_erase;
        toggle_q  <= use_toggle;
        exp_q     <= exp_data;
        addr_q    <= addr;
        limit_q   <= max_reads;
        poll_cnt  <= '0;
        have_prev <= 1'b0;
      end
      if (poll_ack) begin
        poll_cnt  <= poll_cnt + 1'b1;
        have_prev <= 1'b1;
        prev_bit  <= rd_data[TGL];
        if (!poll_hit && poll_last) begin
          done_q    <= 1'b1;
          timeout_q <= 1'b1;
        end
      end
      if (final_ack) begin
        done_q     <= 1'b1;
        mismatch_q <= !erase_q && (rd_data != exp_q);
      end
    end
  end

  assign rd_req   = (state == ST_READ) || (state == ST_FINAL);
  assign rd_addr  = addr_q;
  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign timeout  = timeout_q;
  assign mismatch = mismatch_q;

  AST_READ_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && $past(state) == ST_WAIT_CMD) |-> $past(cmd_wr_done));  // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));  // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R4
  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (done && !mismatch));  // R7
  AST_POLL_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && limit_q != '0) |-> (poll_cnt <= limit_q));  // R7
  AST_MISMATCH_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> (done && !erase_q));  // R8
  AST_FINAL_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FINAL && $past(state) != ST_FINAL) |-> ($past(state) == ST_SETTLE && $past(tmr_zero)));  // R4
  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(exp_q) && $stable(erase_q) && $stable(addr_q)));  // R9

endmodule

// File: tb/test_flash_done_poller.sv
module test_flash_done_poller;

  localparam int AW = 20;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int GAP = 4;
  localparam int SETTLE = 50;
  localparam int LAT = 2;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op_erase = 1'b0;
  logic          use_toggle = 1'b0;
  logic [DW-1:0] exp_data = '0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] max_reads = '0;
  logic          cmd_wr_done = 1'b0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          busy, done, timeout, mismatch;

  flash_done_poller #(.AW(AW), .DW(DW), .CW(CW), .GAP_CYC(GAP), .SETTLE_CYC(SETTLE)) i_flash_done_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase), .use_toggle(use_toggle),
    .exp_data(exp_data), .addr(addr), .max_reads(max_reads), .cmd_wr_done(cmd_wr_done),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done(done), .timeout(timeout), .mismatch(mismatch)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int n_cycles = 0;

  // scenario seen by the device model
  bit          scn_erase;
  logic [7:0]  scn_exp;
  logic [7:0]  scn_fin;
  int          scn_busy;
  logic [AW-1:0] scn_addr;

  // monitor totals
  int rd_total = 0;
  int n_gap = 0, n_settle = 0, n_other = 0;
  int addr_bad = 0;

  // entries: {erase, toggle, exp[7:0], final[7:0], busy_reads[7:0], max_reads[7:0]}
  localparam logic [33:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 8'hA5, 8'hA5, 8'd3,  8'd20},
    {1'b0, 1'b0, 8'h3C, 8'h3C, 8'd0,  8'd5},
    {1'b1, 1'b0, 8'h00, 8'hFF, 8'd5,  8'd20},
    {1'b0, 1'b1, 8'h5A, 8'h5A, 8'd4,  8'd20},
    {1'b0, 1'b1, 8'h12, 8'h12, 8'd3,  8'd20},
    {1'b1, 1'b1, 8'h00, 8'hFF, 8'd2,  8'd20},
    {1'b0, 1'b0, 8'h81, 8'h80, 8'd2,  8'd20},
    {1'b0, 1'b0, 8'h77, 8'h77, 8'd10, 8'd4},
    {1'b1, 1'b1, 8'h00, 8'hFF, 8'd0,  8'd20},
    {1'b0, 1'b0, 8'h42, 8'h42, 8'd0,  8'd0},
    {1'b0, 1'b1, 8'h00, 8'h00, 8'd2,  8'd20},
    {1'b1, 1'b0, 8'h00, 8'hFF, 8'd2,  8'd0}
  };

  // device read value: busy phase, one half-valid read, then settled data
  function automatic logic [7:0] mbyte(int i, bit er, logic [7:0] ex, logic [7:0] fin, int bz);
    logic b7;
    if (i < bz) begin
      b7 = er ? 1'b0 : ~ex[7];
      return {b7, i[0], 6'h15};
    end else if (i == bz) begin
      return {fin[7:6], ~fin[5:0]};
    end
    return fin;
  endfunction

  // read index (1-based) at which the selected rule fires, 0 if never
  function automatic int exp_polls(bit er, bit tg, logic [7:0] ex, logic [7:0] fin, int bz);
    bit pv = 1'b0;
    bit pb = 1'b0;
    for (int i = 0; i < 300; i++) begin
      logic [7:0] b;
      bit hit;
      b = mbyte(i, er, ex, fin, bz);
      if (tg) hit = pv && (b[6] == pb);
      else    hit = er ? b[7] : (b[7] == ex[7]);
      if (hit) return i + 1;
      pv = 1'b1;
      pb = b[6];
    end
    return 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      n_cycles++;
      if (n_cycles > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", n_cycles, 150000);
        finish_run();
      end
    end
  end

  // device model: fixed latency, one-cycle acknowledge
  initial begin
    int idx = 0;
    int lat = 0;
    bit pbusy = 1'b0;
    forever begin
      @(negedge clk);
      if (busy && !pbusy) idx = 0;
      pbusy = busy;
      if (rd_ack) begin
        rd_ack = 1'b0;
        idx++;
        rd_total++;
      end else if (rd_req) begin
        if (rd_addr != scn_addr) addr_bad++;
        if (lat == LAT) begin
          rd_ack  = 1'b1;
          rd_data = mbyte(idx, scn_erase, scn_exp, scn_fin, scn_busy);
          lat = 0;
        end else begin
          lat++;
        end
      end
    end
  end

  // low-time runs of rd_req inside an operation
  initial begin
    bit prev = 1'b0;
    bit in_run = 1'b0;
    int run = 0;
    forever begin
      @(negedge clk);
      if (!rd_req) begin
        if (prev && busy) begin
          in_run = 1'b1;
          run = 1;
        end else if (in_run) begin
          run++;
        end
      end else begin
        if (!prev && in_run) begin
          if (run == GAP) n_gap++;
          else if (run == SETTLE) n_settle++;
          else n_other++;
        end
        in_run = 1'b0;
      end
      prev = rd_req;
    end
  end

  task automatic run_op(bit er, bit tg, logic [7:0] ex, logic [7:0] fin, int bz, int mr,
                        logic [AW-1:0] ad, bit poke);
    int polls, eff, reads, g0, s0, o0, r0, a0, wait_cyc;
    bit exp_to, exp_mm, early_req;
    string rq;
    rq = tg ? "R3" : (er ? "R2" : "R1");
    polls  = exp_polls(er, tg, ex, fin, bz);
    eff    = (mr == 0) ? 1 : mr;
    exp_to = (polls == 0) || (polls > eff);
    reads  = exp_to ? eff : polls;
    exp_mm = !exp_to && !er && (fin != ex);
    scn_erase = er; scn_exp = ex; scn_fin = fin; scn_busy = bz; scn_addr = ad;
    g0 = n_gap; s0 = n_settle; o0 = n_other; r0 = rd_total; a0 = addr_bad;
    @(negedge clk);
    start = 1'b1; op_erase = er; use_toggle = tg; exp_data = ex; addr = ad;
    max_reads = CW'(mr);
    @(negedge clk);
    start = 1'b0;
    early_req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (rd_req) early_req = 1'b1;
      if (poke && k == 1) begin
        start = 1'b1; op_erase = ~er; use_toggle = ~tg; exp_data = ~ex; addr = ~ad;
        max_reads = 8'd1;
      end else if (poke && k == 2) begin
        start = 1'b0;
      end
    end
    check("R5", "request before command end", int'(early_req), 0);
    cmd_wr_done = 1'b1;
    @(negedge clk);
    cmd_wr_done = 1'b0;
    check("R5", "request after command end", int'(rd_req), 1);
    wait_cyc = 0;
    while (!done && wait_cyc < 5000) begin
      @(negedge clk);
      wait_cyc++;
    end
    check(rq, "done seen", int'(done), 1);
    check("R7", "timeout", int'(timeout), int'(exp_to));
    check("R8", "mismatch", int'(mismatch), int'(exp_mm));
    check("R4", "busy with done", int'(busy), 0);
    @(negedge clk);
    check("R4", "done one cycle", int'(done), 0);
    check(rq, "read count", rd_total - r0, reads + (exp_to ? 0 : 1));
    check("R6", "gap runs", n_gap - g0, reads - 1);
    check("R4", "settle runs", n_settle - s0, exp_to ? 0 : 1);
    check("R6", "odd runs", n_other - o0, 0);
    check("R6", "address errors", addr_bad - a0, 0);
  endtask

  initial begin
    scn_erase = 1'b0; scn_exp = '0; scn_fin = '0; scn_busy = 0; scn_addr = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "busy in reset", int'(busy), 0);
    check("R9", "rd_req in reset", int'(rd_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "done after reset", int'(done), 0);
    check("R9", "timeout after reset", int'(timeout), 0);
    check("R9", "mismatch after reset", int'(mismatch), 0);

    for (int v = 0; v < NV; v++) begin
      logic [33:0] e;
      e = VEC[v];
      run_op(e[33], e[32], e[31:24], e[23:16], int'(e[15:8]), int'(e[7:0]),
             AW'(32'h1000 + v * 32'h111), 1'b0);
    end

    // R9: start while busy must not disturb the running program
    run_op(1'b0, 1'b0, 8'hC3, 8'hC3, 3, 20, 20'h5A5A5, 1'b1);

    // R9: command-end pulse while idle starts nothing
    begin
      int r0;
      r0 = rd_total;
      @(negedge clk);
      cmd_wr_done = 1'b1;
      @(negedge clk);
      cmd_wr_done = 1'b0;
      repeat (6) @(negedge clk);
      check("R9", "busy after idle command end", int'(busy), 0);
      check("R9", "reads after idle command end", rd_total - r0, 0);
    end

    finish_run();
  end

endmodule